// File: doc/BRIEF.md
# Programmable GPIO Port Controller

A bank of 8-bit general-purpose I/O ports reached through a small register interface. Every port has a direction register and a data register backed by an output latch. Pull-up enables are held per 4-pin group in separate pull-up registers. Reads of a data register mix synchronised pin levels and latch contents according to direction. One selectable port can be switched so that its reads always return the latch.

An external bus-mode input marks the time when some pins serve as an external memory bus. A parameter mask picks those pins. While the mode is high, writes to their direction and data bits are dropped, and the pull-ups of the bus pin groups are disconnected. Ports above a base count are usable only while a gate bit in the pull-up space is set. One pin is input-only.

Address map: `addr_i[7:4]` selects the page and `addr_i[3:0]` selects the index. Page 0x0 holds data for port n at index n. Page 0x1 holds direction for port n at index n. Page 0x2 holds the pull-up registers: register r holds group enables 8r..8r+7, and group g covers pins 4g..4g+3. Page 0x3 index 0 is the control register. Writes take one cycle and reads are combinational.

Top module: `gpio_bank`

## Requirements
- R1: After reset all direction, data, pull-up and control registers read 0, and `pin_oe_o` and `pull_en_o` are all 0.
- R2: Direction bit 1 selects output and 0 selects input; `pin_oe_o` follows the effective direction and `pin_o` always carries the latch.
- R3: A data write updates the latch whatever the direction; a data read returns the latch for output bits.
- R4: A data read returns the pin level for input bits through a two-flop synchroniser: a pin change is visible after two rising edges, not after one.
- R5: `pull_en_o` of a pin is 1 only when its group bit (bit g of the pull-up space, pin i in group i/4) is set and the pin is effectively an input.
- R6: When control bit 0 is 1, reads of port FORCE_PORT (default 1) return the latch on every bit; when it is 0, they follow R3/R4.
- R7: While `bus_mode_i` is 1, writes to direction and data bits of pins in BUS_MASK leave them unchanged; other bits are written; with `bus_mode_i` at 0 all bits are writable.
- R8: While `bus_mode_i` is 1, `pull_en_o` is 0 for groups in BUS_PU_MASK, and the pull-up registers stay writable and readable.
- R9: Pin IN_ONLY_PIN (default 29, port 3 bit 5) has no direction bit: it reads 0, ignores writes and is never driven.
- R10: Ports at index BASE_PORTS (default 4) and above stay in input mode with no drive while bit 15 of the pull-up space (register 1 bit 7) is 0; their data reads then return the pin.
- R11: Reads of unmapped addresses, or of data/direction indices at or above NUM_PORTS, return 0; control register bits 7:1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_mode_i | input | 1 | External bus mode active |
| addr_i | input | 8 | Register address (page, index) |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| pin_i | input | NUM_PORTS*8 | Pad input levels |
| pin_o | output | NUM_PORTS*8 | Pad output levels (latch) |
| pin_oe_o | output | NUM_PORTS*8 | Pad output enable |
| pull_en_o | output | NUM_PORTS*8 | Pad pull-up enable |

## Verification
Each port is swept with direction, latch and pin patterns drawn from distinct arithmetic sequences. A mix-up between latch and pin, or a bit-order slip on the read path, therefore shows up on some bit. Pull-up patterns are crossed with direction patterns, which separates the direction gating from the group decoding. The same writes are repeated with the bus mode on and then off, so the bench can tell write protection that depends on the mode from protection that is always on. A single pin step measured one and two edges later pins down the synchroniser depth.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [3:0] PG_DATA = 4'h0;
  localparam logic [3:0] PG_DIR  = 4'h1;
  localparam logic [3:0] PG_PULL = 4'h2;
  localparam logic [3:0] PG_CTRL = 4'h3;

  function automatic int pull_regs(input int nports);
    return (2 * nports) / 8 + 1;  // one spare bit left for the gate
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter logic [7:0] LOCK_MASK    = 8'h00,
  parameter logic [7:0] IN_ONLY_MASK = 8'h00,
  parameter bit         FORCE_EN     = 1'b0,
  parameter bit         EXTRA        = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bus_mode_i,
  input  logic       dat_we_i,
  input  logic       dir_we_i,
  input  logic [7:0] wdata_i,
  input  logic       force_latch_i,
  input  logic       ext_en_i,
  input  logic [7:0] pin_sync_i,
  output logic [7:0] dir_o,
  output logic [7:0] latch_o,
  output logic [7:0] oe_o,
  output logic [7:0] rd_o
);
  logic [7:0] dir_q, lat_q, lock;

  assign lock = bus_mode_i ? LOCK_MASK : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      lat_q <= '0;
    end else begin
      if (dir_we_i) dir_q <= ((dir_q & lock) | (wdata_i & ~lock)) & ~IN_ONLY_MASK;
      if (dat_we_i) lat_q <= (lat_q & lock) | (wdata_i & ~lock);
    end
  end

  assign oe_o    = (EXTRA && !ext_en_i) ? 8'h00 : dir_q;
  assign dir_o   = dir_q;
  assign latch_o = lat_q;
  assign rd_o    = (FORCE_EN && force_latch_i) ? lat_q
                 : ((oe_o & lat_q) | (~oe_o & pin_sync_i));

  a_r3_latch_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_we_i && !bus_mode_i |=> lat_q == $past(wdata_i));
  a_r7_lock_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_mode_i && dat_we_i |=> (lat_q & LOCK_MASK) == $past(lat_q & LOCK_MASK));
  a_r7_lock_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_mode_i && dir_we_i |=> (dir_q & LOCK_MASK) == $past(dir_q & LOCK_MASK));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int BASE_PORTS  = 4,
  parameter int FORCE_PORT  = 1,
  parameter int IN_ONLY_PIN = 29,
  parameter logic [NUM_PORTS*8-1:0] BUS_MASK    = 48'h0000_000F_FFFF,
  parameter logic [2*NUM_PORTS-1:0] BUS_PU_MASK = 12'h00F
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_mode_i,
  input  logic [7:0]             addr_i,
  input  logic                   we_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  input  logic [NUM_PORTS*8-1:0] pin_i,
  output logic [NUM_PORTS*8-1:0] pin_o,
  output logic [NUM_PORTS*8-1:0] pin_oe_o,
  output logic [NUM_PORTS*8-1:0] pull_en_o
);
  localparam int W       = NUM_PORTS * 8;
  localparam int PU_REGS = pull_regs(NUM_PORTS);
  localparam int PU_W    = PU_REGS * 8;
  localparam int EXT_BIT = PU_W - 1;

  logic [3:0]      page, idx;
  logic [W-1:0]    pin_sync;
  logic [PU_W-1:0] pu_q;
  logic            ctrl_q;
  logic [7:0]      port_rd  [NUM_PORTS];
  logic [7:0]      port_dir [NUM_PORTS];

  assign page = addr_i[7:4];
  assign idx  = addr_i[3:0];

  gpio_sync #(.WIDTH(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar r = 0; r < PU_REGS; r++) begin : g_pull_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pu_q[r*8 +: 8] <= '0;
      else if (we_i && page == PG_PULL && idx == 4'(r)) pu_q[r*8 +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 1'b0;
    else if (we_i && page == PG_CTRL && idx == 4'd0) ctrl_q <= wdata_i[0];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [7:0] IOM = (IN_ONLY_PIN / 8 == p) ? (8'h01 << (IN_ONLY_PIN % 8)) : 8'h00;
    logic [7:0] oe, lat;

    gpio_port #(
      .LOCK_MASK   (BUS_MASK[p*8 +: 8]),
      .IN_ONLY_MASK(IOM),
      .FORCE_EN    (p == FORCE_PORT),
      .EXTRA       (p >= BASE_PORTS)
    ) u_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .bus_mode_i   (bus_mode_i),
      .dat_we_i     (we_i && page == PG_DATA && idx == 4'(p)),
      .dir_we_i     (we_i && page == PG_DIR && idx == 4'(p)),
      .wdata_i      (wdata_i),
      .force_latch_i(ctrl_q),
      .ext_en_i     (pu_q[EXT_BIT]),
      .pin_sync_i   (pin_sync[p*8 +: 8]),
      .dir_o        (port_dir[p]),
      .latch_o      (lat),
      .oe_o         (oe),
      .rd_o         (port_rd[p])
    );

    assign pin_o[p*8 +: 8]    = lat;
    assign pin_oe_o[p*8 +: 8] = oe;
  end

  for (genvar i = 0; i < W; i++) begin : g_pull
    assign pull_en_o[i] = pu_q[i/4] && !pin_oe_o[i] && !(bus_mode_i && BUS_PU_MASK[i/4]);
  end

  always_comb begin
    rdata_o = 8'h00;
    unique case (page)
      PG_DATA: for (int p = 0; p < NUM_PORTS; p++) if (idx == 4'(p)) rdata_o = port_rd[p];
      PG_DIR:  for (int p = 0; p < NUM_PORTS; p++) if (idx == 4'(p)) rdata_o = port_dir[p];
      PG_PULL: for (int r = 0; r < PU_REGS; r++) if (idx == 4'(r)) rdata_o = pu_q[r*8 +: 8];
      PG_CTRL: if (idx == 4'd0) rdata_o = {7'b0, ctrl_q};
      default: rdata_o = 8'h00;
    endcase
  end

  a_r5_pull_only_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_en_o & pin_oe_o) == '0);
  a_r9_never_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o[IN_ONLY_PIN]);
  if (BASE_PORTS < NUM_PORTS) begin : g_gate_chk
    a_r10_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pu_q[EXT_BIT] |-> pin_oe_o[W-1:BASE_PORTS*8] == '0);
  end
endmodule

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  localparam int NP   = 6;
  localparam int BASE = 4;
  localparam int FP   = 1;
  localparam int INO  = 29;
  localparam logic [NP*8-1:0] BUSM  = 48'h0000_000F_FFFF;
  localparam logic [2*NP-1:0] BUSPU = 12'h00F;

  logic clk = 0, rst_n = 0, bus = 0, we = 0;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [NP*8-1:0] pins, pout, poe, pull;
  int checks = 0, errors = 0;

  logic [7:0] dir_m [NP];
  logic [7:0] lat_m [NP];
  logic [7:0] pin_m [NP];
  logic [15:0] pu_m;
  logic ctrl_m;

  always #10 clk = ~clk;

  always_comb for (int p = 0; p < NP; p++) pins[p*8 +: 8] = pin_m[p];

  gpio_bank #(.NUM_PORTS(NP), .BASE_PORTS(BASE), .FORCE_PORT(FP), .IN_ONLY_PIN(INO),
              .BUS_MASK(BUSM), .BUS_PU_MASK(BUSPU)) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_mode_i(bus), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins), .pin_o(pout),
    .pin_oe_o(poe), .pull_en_o(pull));

  function automatic logic [7:0] iom(int p);
    return (p == INO / 8) ? (8'h01 << (INO % 8)) : 8'h00;
  endfunction
  function automatic logic [7:0] eff(int p);
    return (p >= BASE && !pu_m[15]) ? 8'h00 : dir_m[p];
  endfunction
  function automatic logic [7:0] exp_rd(int p);
    if (ctrl_m && p == FP) return lat_m[p];
    return (eff(p) & lat_m[p]) | (~eff(p) & pin_m[p]);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    logic [7:0] lock;
    int i;
    @(negedge clk);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
    i = int'(a[3:0]);
    case (a[7:4])
      4'h0: if (i < NP) begin
        lock = bus ? BUSM[i*8 +: 8] : 8'h00;
        lat_m[i] = (lat_m[i] & lock) | (d & ~lock);
      end
      4'h1: if (i < NP) begin
        lock = bus ? BUSM[i*8 +: 8] : 8'h00;
        dir_m[i] = ((dir_m[i] & lock) | (d & ~lock)) & ~iom(i);
      end
      4'h2: if (i < 2) pu_m[i*8 +: 8] = d;
      4'h3: if (i == 0) ctrl_m = d[0];
      default: ;
    endcase
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic verify(string tag);
    logic [7:0] d;
    logic [NP*8-1:0] e_oe, e_out, e_pull;
    for (int p = 0; p < NP; p++) begin
      rd(8'(p), d);        chk({tag, " data"}, d, exp_rd(p));
      rd(8'h10 + 8'(p), d); chk({tag, " dir"}, d, dir_m[p]);
      e_oe[p*8 +: 8] = eff(p);
      e_out[p*8 +: 8] = lat_m[p];
    end
    for (int i = 0; i < NP * 8; i++)
      e_pull[i] = pu_m[i/4] && !e_oe[i] && !(bus && BUSPU[i/4]);
    rd(8'h20, d); chk({tag, " pull0"}, d, pu_m[7:0]);
    rd(8'h21, d); chk({tag, " pull1"}, d, pu_m[15:8]);
    rd(8'h30, d); chk({tag, " ctrl"}, d, {7'b0, ctrl_m});
    chk({tag, " pin_o"}, pout, e_out);
    chk({tag, " pin_oe"}, poe, e_oe);
    chk({tag, " pull_en"}, pull, e_pull);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    for (int p = 0; p < NP; p++) begin dir_m[p] = 0; lat_m[p] = 0; pin_m[p] = 0; end
    pu_m = 0; ctrl_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    verify("R1");

    // R2/R3: per-port sweep with gate open
    wr(8'h21, 8'h80);
    for (int p = 0; p < NP; p++)
      for (int k = 0; k < 4; k++) begin
        wr(8'h10 + 8'(p), 8'(p * 37 + k * 91));
        wr(8'(p), 8'(k * 53 + p * 11 + 7));
        pin_m[p] = 8'((p * 29) ^ (k * 77 + 3));
        settle();
        verify("R2/R3");
      end

    // R4: synchroniser depth
    wr(8'h10, 8'h00);
    pin_m[0] = 8'h00; settle();
    @(negedge clk); pin_m[0] = 8'h3C; addr = 8'h00;
    @(negedge clk); #1 chk("R4 one edge", rdata, 8'h00);
    @(negedge clk); #1 chk("R4 two edges", rdata, 8'h3C);

    // R5: pull groups crossed with directions
    for (int k = 0; k < 4; k++) begin
      wr(8'h20, 8'(k * 90 + 51));
      wr(8'h21, 8'h80 | 8'(k * 5 + 6));
      for (int p = 0; p < NP; p++) wr(8'h10 + 8'(p), 8'((p + 1) * (k + 3) * 17));
      verify("R5");
    end

    // R6: forced latch reads
    wr(8'h11, 8'h0F); wr(8'h01, 8'h96); pin_m[1] = 8'h3A; settle();
    wr(8'h30, 8'hFF);
    verify("R6");
    rd(8'h01, d); chk("R6 forced", d, 8'h96);
    wr(8'h30, 8'h00);
    verify("R6");

    // R7: bus-mode write protection, then unlocked
    @(negedge clk); bus = 1;
    for (int p = 0; p < NP; p++) begin
      wr(8'h10 + 8'(p), 8'(~(p * 19)));
      wr(8'(p), 8'(p * 45 + 9));
    end
    verify("R7");
    rd(8'h02, d);
    @(negedge clk); bus = 0;
    for (int p = 0; p < NP; p++) begin
      wr(8'h10 + 8'(p), 8'(p * 23 + 1));
      wr(8'(p), 8'(~(p * 31)));
    end
    verify("R7");

    // R8: bus pull-ups disconnected, registers still usable
    for (int p = 0; p < NP; p++) wr(8'h10 + 8'(p), 8'h00);
    wr(8'h20, 8'hFF); wr(8'h21, 8'h8F);
    @(negedge clk); bus = 1;
    verify("R8");
    wr(8'h20, 8'h5A);
    verify("R8");
    @(negedge clk); bus = 0;
    verify("R8");

    // R9: input-only pin
    wr(8'h13, 8'hFF);
    rd(8'h13, d); chk("R9 dir bit", {7'b0, d[INO % 8]}, 0);
    chk("R9 oe", {63'b0, poe[INO]}, 0);
    verify("R9");

    // R10: extra ports gated
    wr(8'h14, 8'hFF); wr(8'h15, 8'hFF); wr(8'h04, 8'hC3);
    pin_m[4] = 8'h18; settle();
    wr(8'h21, 8'h00);
    chk("R10 oe off", {16'b0, poe[47:32]}, 0);
    rd(8'h04, d); chk("R10 pin read", d, 8'h18);
    verify("R10");
    wr(8'h21, 8'h80);
    verify("R10");

    // R11: unmapped reads
    wr(8'h30, 8'hFE);
    rd(8'h30, d); chk("R11 ctrl upper", d, 8'h00);
    rd(8'h06, d); chk("R11 data idx", d, 8'h00);
    rd(8'h1F, d); chk("R11 dir idx", d, 8'h00);
    rd(8'h22, d); chk("R11 pull idx", d, 8'h00);
    rd(8'h31, d); chk("R11 ctrl idx", d, 8'h00);
    rd(8'h7A, d); chk("R11 page", d, 8'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule